// File: doc/BRIEF.md
# PCM Bus Time-Slot Receiver

This block pulls one channel's sample out of a serial time-division-multiplexed PCM stream. A frame-sync pulse marks the start of each frame. The serial data is sampled on the falling edge of a bit clock. Both signals are treated as slow inputs that are synchronous to the block's system clock, and each falling edge of the bit clock is detected in that clock domain. The bit marked by frame sync carries no data. Slot 0 begins at the next bit. Each slot is eight bits long and arrives most significant bit first.

A configuration word selects the slot. Its top bit is a receive enable and the bits below it give the slot number. A separate input chooses companded or linear mode. In companded mode the eight bits of the chosen slot are delivered as one sample. In linear mode a 16-bit word is assembled. Its upper byte comes from the chosen slot and its lower byte from the slot after it. When the last slot is chosen, the lower byte comes from slot 0 of the following frame. Every finished sample appears on a parallel output together with a strobe that lasts one clock. The configuration is taken up only at a frame-sync bit, so a write in the middle of a frame never produces a partial capture.

Top module: `pcmSlotRx`

## Requirements
- R1: After reset the held configuration is all zeros (disabled, slot 0). `sampleValid` and `sampleOut` are 0.
- R2: While the held enable bit (bit SLOT_W of `slotCfg`) is 0, no `sampleValid` pulse is produced.
- R3: Bits SLOT_W-1..0 of `slotCfg` choose the slot. Slot 0 starts at the first bit after the bit sampled with `frameSync` high. Each slot holds 8 bits, most significant bit first, and each bit is sampled at a falling edge of `bitClk`.
- R4: In companded mode (`linearMode`=0), `sampleOut[7:0]` carries the chosen slot's byte and `sampleOut[15:8]` is 0. The sample is delivered once per frame, at the end of the chosen slot.
- R5: In linear mode (`linearMode`=1), `sampleOut[15:8]` is the byte of the chosen slot.
- R6: In linear mode, `sampleOut[7:0]` is the byte of the next slot. `sampleValid` pulses only after that byte has arrived.
- R7: In linear mode with the last slot chosen, the lower byte is slot 0 of the next frame.
- R8: `slotCfg` and `linearMode` are sampled only on a frame-sync bit. A change made during a frame has no effect until the next frame.
- R9: `sampleValid` is high for exactly one clock per sample.
- R10: Before the first frame-sync bit after reset, nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bitClk | input | 1 | Serial bit clock; data sampled at its falling edge |
| frameSync | input | 1 | Frame marker, sampled with the data bit |
| dataIn | input | 1 | Serial PCM data |
| slotCfg | input | SLOT_W+1 | Enable (top bit) and slot number |
| linearMode | input | 1 | 1 = 16-bit linear over two slots, 0 = 8-bit companded |
| sampleOut | output | 16 | Received sample |
| sampleValid | output | 1 | One-clock strobe marking a new sample |

## Verification
The bench sweeps every slot of a 16-slot frame in both modes. Each slot carries a distinct byte that depends on the frame and slot numbers, so a design that counted slots or bits off by one, or shifted the bit order, would return a neighbour's byte. Choosing the last slot in linear mode checks the wrap into the next frame's slot 0. A design that wrapped inside the same frame, or that gave up the pending byte at the frame boundary, would output a wrong low byte or too few samples. Configuration changes in the middle of a frame, in both directions, catch a design that applies the new setting at once. Disabled sweeps, and bits sent before any frame sync, catch spurious strobes.

// File: rtl/pcmSlotRxPkg.sv
package pcmSlotRxPkg;
  localparam int BYTE_W   = 8;
  localparam int SAMPLE_W = 2 * BYTE_W;

  typedef struct packed {
    logic shiftEn;    // sample one serial bit this cycle
    logic byteDone;   // the sampled bit completes a slot
    logic hitHigh;    // completed slot is the configured one and reception is on
    logic linearSel;  // held mode: 1 = linear
  } rxStrobe_t;
endpackage

// File: rtl/pcmSlotRxCtrl.sv
module pcmSlotRxCtrl
  import pcmSlotRxPkg::*;
#(
  parameter int SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitClk,
  input  logic              frameSync,
  input  logic [SLOT_W:0]   slotCfg,
  input  logic              linearMode,
  output rxStrobe_t         strb,
  output logic [SLOT_W-1:0] slotNum
);
  localparam int CNT_W = SLOT_W + 3;

  logic              bitClkQ;
  logic              live;
  logic              actEn;
  logic              actLin;
  logic [SLOT_W-1:0] actSlot;
  logic [CNT_W-1:0]  bitCnt;
  logic              fallEdge;

  assign fallEdge = bitClkQ & ~bitClk;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitClkQ <= 1'b0;
      live    <= 1'b0;
      actEn   <= 1'b0;
      actLin  <= 1'b0;
      actSlot <= '0;
      bitCnt  <= '0;
    end else begin
      bitClkQ <= bitClk;
      if (fallEdge) begin
        if (frameSync) begin
          bitCnt  <= '0;
          live    <= 1'b1;
          actEn   <= slotCfg[SLOT_W];
          actSlot <= slotCfg[SLOT_W-1:0];
          actLin  <= linearMode;
        end else if (live) begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  assign slotNum = bitCnt[CNT_W-1:3];

  always_comb begin
    strb.shiftEn   = fallEdge & ~frameSync & live;
    strb.byteDone  = strb.shiftEn & (bitCnt[2:0] == 3'd7);
    strb.hitHigh   = strb.byteDone & actEn & (slotNum == actSlot);
    strb.linearSel = actLin;
  end

  // Held configuration only moves on a frame-sync bit.
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(fallEdge && frameSync) |=> $stable({actEn, actLin, actSlot}));

  // Each sampled data bit advances the position by exactly one.
  assert_bit_step_R3: assert property (@(posedge clk) disable iff (rst)
    (fallEdge && !frameSync && live) |=> (bitCnt == CNT_W'($past(bitCnt) + 1'b1)));
endmodule

// File: rtl/pcmSlotRxData.sv
module pcmSlotRxData
  import pcmSlotRxPkg::*;
#(
  parameter int SLOT_W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dataIn,
  input  rxStrobe_t           strb,
  input  logic [SLOT_W-1:0]   slotNum,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                sampleValid
);
  logic [BYTE_W-2:0] shiftReg;
  logic [BYTE_W-1:0] curByte;
  logic [BYTE_W-1:0] hiByte;
  logic [SLOT_W-1:0] lowSlot;
  logic              waitLow;
  logic              lowDone;

  assign curByte = {shiftReg, dataIn};
  assign lowDone = strb.byteDone & waitLow & (slotNum == lowSlot);

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg    <= '0;
      hiByte      <= '0;
      lowSlot     <= '0;
      waitLow     <= 1'b0;
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      if (strb.shiftEn) shiftReg <= curByte[BYTE_W-2:0];
      if (lowDone) begin
        sampleOut   <= {hiByte, curByte};
        sampleValid <= 1'b1;
        waitLow     <= 1'b0;
      end
      if (strb.hitHigh) begin
        if (strb.linearSel) begin
          hiByte  <= curByte;
          lowSlot <= slotNum + 1'b1;  // wraps to slot 0 of next frame
          waitLow <= 1'b1;
        end else if (!lowDone) begin
          sampleOut   <= {{BYTE_W{1'b0}}, curByte};
          sampleValid <= 1'b1;
        end
      end
    end
  end

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid);

  assert_low_done_R6: assert property (@(posedge clk) disable iff (rst)
    (strb.byteDone && waitLow && slotNum == lowSlot) |=> sampleValid);

  assert_comp_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && !$past(waitLow)) |-> (sampleOut[SAMPLE_W-1:BYTE_W] == '0));
endmodule

// File: rtl/pcmSlotRx.sv
module pcmSlotRx
  import pcmSlotRxPkg::*;
#(
  parameter int SLOT_W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bitClk,
  input  logic                frameSync,
  input  logic                dataIn,
  input  logic [SLOT_W:0]     slotCfg,
  input  logic                linearMode,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                sampleValid
);
  rxStrobe_t         strb;
  logic [SLOT_W-1:0] slotNum;

  pcmSlotRxCtrl #(.SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rst(rst), .bitClk(bitClk), .frameSync(frameSync),
    .slotCfg(slotCfg), .linearMode(linearMode), .strb(strb), .slotNum(slotNum)
  );

  pcmSlotRxData #(.SLOT_W(SLOT_W)) u_data (
    .clk(clk), .rst(rst), .dataIn(dataIn), .strb(strb), .slotNum(slotNum),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );
endmodule

// File: tb/pcmSlotRx_bench.sv
module pcmSlotRx_bench;
  localparam int SW = 4;
  localparam int NS = 1 << SW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bitClk = 1'b0;
  logic          frameSync = 1'b0;
  logic          dataIn = 1'b0;
  logic [SW:0]   slotCfg = '0;
  logic          linearMode = 1'b0;
  logic [15:0]   sampleOut;
  logic          sampleValid;

  int checks = 0;
  int errors = 0;
  int nv = 0;
  logic [15:0] got [0:7];
  int fr = 0;

  always #10 clk = ~clk;  // 50 MHz

  pcmSlotRx #(.SLOT_W(SW)) u_pcmSlotRx (
    .clk(clk), .rst(rst), .bitClk(bitClk), .frameSync(frameSync),
    .dataIn(dataIn), .slotCfg(slotCfg), .linearMode(linearMode),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  always @(negedge clk) begin
    if (!rst && sampleValid) begin
      if (nv < 8) got[nv] = sampleOut;
      nv = nv + 1;
    end
  end

  function automatic logic [7:0] byteOf(int f, int s);
    return 8'((f * 37 + s * 11 + 5) & 255);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic driveBit(logic fs, logic d);
    frameSync = fs;
    dataIn    = d;
    bitClk    = 1'b1;
    repeat (2) @(negedge clk);
    bitClk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic runFrame(int f, bit doMid, logic [SW:0] midCfg, logic midLin);
    driveBit(1'b1, 1'b0);
    for (int s = 0; s < NS; s++) begin
      logic [7:0] b;
      b = byteOf(f, s);
      for (int k = 0; k < 8; k++) begin
        if (doMid && s == NS / 2 && k == 0) begin
          slotCfg    = midCfg;
          linearMode = midLin;
        end
        driveBit(1'b0, b[7-k]);
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    slotCfg = {1'b1, 4'd0};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset sampleValid", 32'(sampleValid), 0);
    chk("R1 reset sampleOut", 32'(sampleOut), 0);
    // R10: bits with no frame sync yet
    nv = 0;
    for (int i = 0; i < 40; i++) driveBit(1'b0, 1'(i % 3 == 0));
    chk("R10 no capture before first sync", nv, 0);

    // Companded and linear sweeps over every slot (R3 R4 R5 R6 R7)
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < NS; s++) begin
        logic [15:0] e0, e1;
        slotCfg    = {1'b1, 4'(s)};
        linearMode = 1'(lin);
        nv = 0;
        runFrame(fr, 0, '0, 0);
        runFrame(fr + 1, 0, '0, 0);
        slotCfg = '0;
        runFrame(fr + 2, 0, '0, 0);
        if (lin == 0) begin
          e0 = {8'h00, byteOf(fr, s)};
          e1 = {8'h00, byteOf(fr + 1, s)};
        end else if (s < NS - 1) begin
          e0 = {byteOf(fr, s), byteOf(fr, s + 1)};
          e1 = {byteOf(fr + 1, s), byteOf(fr + 1, s + 1)};
        end else begin
          e0 = {byteOf(fr, s), byteOf(fr + 1, 0)};
          e1 = {byteOf(fr + 1, s), byteOf(fr + 2, 0)};
        end
        if (lin == 0) begin
          chk("R4 one sample per frame", nv, 2);
          chk("R3 R4 companded byte A", 32'(got[0]), 32'(e0));
          chk("R3 R4 companded byte B", 32'(got[1]), 32'(e1));
        end else if (s < NS - 1) begin
          chk("R6 linear sample count", nv, 2);
          chk("R5 R6 linear word A", 32'(got[0]), 32'(e0));
          chk("R5 R6 linear word B", 32'(got[1]), 32'(e1));
        end else begin
          chk("R7 wrap sample count", nv, 2);
          chk("R7 wrap word A", 32'(got[0]), 32'(e0));
          chk("R7 wrap word B", 32'(got[1]), 32'(e1));
        end
        fr += 3;
      end
    end

    // R2: disabled configurations
    for (int lin = 0; lin < 2; lin++) begin
      for (int i = 0; i < 3; i++) begin
        int s;
        s = (i == 0) ? 0 : (i == 1) ? 5 : NS - 1;
        slotCfg    = {1'b0, 4'(s)};
        linearMode = 1'(lin);
        nv = 0;
        runFrame(fr, 0, '0, 0);
        runFrame(fr + 1, 0, '0, 0);
        chk("R2 disabled gives no strobe", nv, 0);
        fr += 2;
      end
    end

    // R8: mid-frame changes
    slotCfg = '0;
    linearMode = 1'b0;
    runFrame(fr, 0, '0, 0);
    fr++;
    nv = 0;
    runFrame(fr, 1, {1'b1, 4'(NS - 1)}, 1'b0);
    chk("R8 enable mid-frame waits", nv, 0);
    runFrame(fr + 1, 0, '0, 0);
    chk("R8 enable applied next frame count", nv, 1);
    chk("R8 enable applied next frame data", 32'(got[0]), 32'({8'h00, byteOf(fr + 1, NS - 1)}));
    runFrame(fr + 2, 1, '0, 1'b0);
    chk("R8 disable mid-frame still captures", nv, 2);
    chk("R8 disable mid-frame data", 32'(got[1]), 32'({8'h00, byteOf(fr + 2, NS - 1)}));
    runFrame(fr + 3, 0, '0, 0);
    chk("R8 disable applied next frame", nv, 2);
    fr += 4;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule